// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block is a write-only serial configuration port for a dual-loop frequency synthesizer. A host drives three wires: a data line, a serial clock and an active-low enable. While enable is low, each rising edge of the serial clock pushes one data bit into a 21-bit frame shift register, most significant bit first. Only the most recent 21 bits are kept. The block does not count the clocks, so any extra leading bits simply fall off the top.

When enable returns high, the block splits the frame. The trailing 4 bits are an address and the 17 bits before them are the payload. The payload is copied into one of five targets: the loop-A divider ratio, the loop-B divider ratio, a control word, a reference word or a test word. The register outputs drive the divider and loop logic directly.

All three wires are sampled into the system clock domain through synchronizers, so the host may be fully asynchronous to the system clock. The dividers raise a busy input while they read their ratio values. A commit that arrives during that window is held and then applied in the first cycle after busy drops. This prevents a divider from ever reading a half-updated ratio.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset every target register reads zero, so both loop run bits are 0 (both loops powered down) and all other outputs are 0.
- R2: Rising serial clock edges while enable is high do not move the frame register. Bits already held stay in place and are used by a later commit.
- R3: The frame register keeps only the latest 21 bits received. Any earlier bits, from the same burst or from an earlier one, are discarded with no count check.
- R4: Bits arrive most significant first. Frame bits [20:4] are the payload and bits [3:0] are the address. The address codes are 0000 for loop-B ratio, 0001 for control, 0100 for loop-A ratio, 0101 for reference and 0110 for test.
- R5: A rising edge of enable commits the frame. The serial clock may be high or low at that moment.
- R6: The control payload is laid out as follows. Bit 0 is the loop-A run bit and bit 1 is the loop-B run bit (0 = powered down). Bits [5:2] are the four port bits and bit 6 is the doubler enable. Bits [8:7] are the lock-indicator select, bit 9 is the loop-A high-current select and bit 10 is the loop-B high-current select. Payload bits [16:11] are discarded.
- R7: In the reference payload, bits [11:0] are the reference ratio and bit 12 selects half-rate reference for loop B. Payload bits [16:13] are discarded.
- R8: Each loop ratio register stores all 17 payload bits, including the legal range limits 512 and 131071.
- R9: A commit whose address matches none of the five codes changes no output.
- R10: While div_busy is high, no output changes. A commit that arrives during busy is applied once busy is low, with no new frame needed.
- R11: When busy is low, the committed value appears on the outputs within 5 system clock cycles of enable going high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; bits shift on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge commits |
| div_busy | input | 1 | Dividers are reading ratios; commits wait |
| run_a | output | 1 | Loop A powered (1) or down (0) |
| run_b | output | 1 | Loop B powered (1) or down (0) |
| port_out | output | 4 | General-purpose port bits |
| dbl_en | output | 1 | Supply doubler enable |
| lock_sel | output | 2 | Lock-indicator output select |
| cp_hi_a | output | 1 | Loop A high charge-pump current |
| cp_hi_b | output | 1 | Loop B high charge-pump current |
| ref_ratio | output | 12 | Reference divider ratio |
| ref_half_b | output | 1 | Loop B uses half-rate reference |
| main_a | output | 17 | Loop A divider ratio |
| main_b | output | 17 | Loop B divider ratio |
| test_word | output | 17 | Test register contents |

## Verification
A wrong internal state shows up in one of three ways. A frame register that shifted during an idle clock, or that lost bits, misroutes or corrupts the next commit, so the error appears on a different target's outputs. A stuck pending flag shows up as a loaded value that is missing five cycles after enable rises, or as a value that changes while busy is high. A bad address decode writes a target that should not have changed. Because of this, every check compares all five targets at once, and the comparison runs immediately after each commit.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam int unsigned LD_DATA_W  = 17;
  localparam int unsigned LD_ADDR_W  = 4;
  localparam int unsigned LD_REF_W   = 12;
  localparam int unsigned LD_N_TGT   = 5;

  // address codes
  localparam logic [3:0] ADR_MAIN_B = 4'b0000;
  localparam logic [3:0] ADR_CTRL   = 4'b0001;
  localparam logic [3:0] ADR_MAIN_A = 4'b0100;
  localparam logic [3:0] ADR_REF    = 4'b0101;
  localparam logic [3:0] ADR_TEST   = 4'b0110;

  // target slots in the register bank
  localparam int unsigned T_MAIN_B = 0;
  localparam int unsigned T_CTRL   = 1;
  localparam int unsigned T_MAIN_A = 2;
  localparam int unsigned T_REF    = 3;
  localparam int unsigned T_TEST   = 4;

  // control payload layout
  localparam int unsigned C_RUN_A   = 0;
  localparam int unsigned C_RUN_B   = 1;
  localparam int unsigned C_PORT_LO = 2;
  localparam int unsigned C_PORT_W  = 4;
  localparam int unsigned C_DBL     = 6;
  localparam int unsigned C_LSEL_LO = 7;
  localparam int unsigned C_LSEL_W  = 2;
  localparam int unsigned C_CPHI_A  = 9;
  localparam int unsigned C_CPHI_B  = 10;
  localparam int unsigned C_USED_W  = 11;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nx;

  always_comb chain_nx = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nx;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned      W       = 3,
  parameter int unsigned      STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q;
  logic [STAGES-1:0][W-1:0] st_nx;

  always_comb st_nx = {st_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {STAGES{RST_VAL}};
    else        st_q <= st_nx;
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned FRAME_W = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sdat,
  input  logic               sen_n,
  output logic [FRAME_W-1:0] frame
);
  logic               sclk_q;
  logic               shift_en;
  logic [FRAME_W-1:0] frame_nx;

  always_comb begin
    shift_en = sclk && !sclk_q && !sen_n;
    frame_nx = {frame[FRAME_W-2:0], sdat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      frame  <= '0;
    end else begin
      sclk_q <= sclk;
      if (shift_en) frame <= frame_nx;
    end
  end

  // R2: idle enable freezes the frame
  a_r2_idle_holds_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sen_n |=> $stable(frame));

  // R3/R4: newest bit enters at the bottom, older bits move up
  a_r3_newest_at_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (frame[0] == $past(sdat)) &&
                 (frame[FRAME_W-1:1] == $past(frame[FRAME_W-2:0])));
endmodule

// File: rtl/cfg_commit.sv
module cfg_commit
  import cfg_loader_pkg::*;
#(
  parameter int unsigned DATA_W  = 17,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned N_TGT   = 5,
  localparam int unsigned FRAME_W = DATA_W + ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sen_n,
  input  logic [FRAME_W-1:0] frame,
  input  logic               div_busy,
  output logic [N_TGT-1:0]   wr_stb,
  output logic [DATA_W-1:0]  wr_data
);
  logic               en_q;
  logic               pend_q, pend_nx;
  logic [FRAME_W-1:0] hold_q, hold_nx;
  logic               rise, fire;
  logic [N_TGT-1:0]   dec;

  always_comb begin
    rise    = sen_n && !en_q;
    fire    = pend_q && !div_busy;
    hold_nx = rise ? frame : hold_q;
    pend_nx = rise ? 1'b1 : (fire ? 1'b0 : pend_q);
  end

  always_comb begin
    dec = '0;
    case (hold_q[ADDR_W-1:0])
      ADR_MAIN_B: dec[T_MAIN_B] = 1'b1;
      ADR_CTRL:   dec[T_CTRL]   = 1'b1;
      ADR_MAIN_A: dec[T_MAIN_A] = 1'b1;
      ADR_REF:    dec[T_REF]    = 1'b1;
      ADR_TEST:   dec[T_TEST]   = 1'b1;
      default:    dec = '0;
    endcase
    wr_stb  = fire ? dec : '0;
    wr_data = hold_q[FRAME_W-1 -: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      pend_q <= 1'b0;
      hold_q <= '0;
    end else begin
      en_q   <= sen_n;
      pend_q <= pend_nx;
      if (rise) hold_q <= hold_nx;
    end
  end

  // R5: a rising enable always leaves a commit pending
  a_r5_rise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> pend_q);

  // R10: a pending commit survives the busy window
  a_r10_pending_kept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && div_busy) |=> pend_q);

  // R4: at most one target written per commit
  a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int unsigned DATA_W = 17,
  parameter int unsigned N_TGT  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_TGT-1:0]              wr_stb,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [N_TGT-1:0][DATA_W-1:0]  words
);
  for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (wr_stb[g]) q <= wr_data;
    end
    assign words[g] = q;
  end

  // R9: with no strobe nothing in the bank moves
  a_r9_no_strobe_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb == '0) |=> $stable(words));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned DATA_W = LD_DATA_W,
  parameter int unsigned ADDR_W = LD_ADDR_W,
  parameter int unsigned REF_W  = LD_REF_W,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_en_n,
  input  logic              div_busy,
  output logic              run_a,
  output logic              run_b,
  output logic [C_PORT_W-1:0] port_out,
  output logic              dbl_en,
  output logic [C_LSEL_W-1:0] lock_sel,
  output logic              cp_hi_a,
  output logic              cp_hi_b,
  output logic [REF_W-1:0]  ref_ratio,
  output logic              ref_half_b,
  output logic [DATA_W-1:0] main_a,
  output logic [DATA_W-1:0] main_b,
  output logic [DATA_W-1:0] test_word
);
  localparam int unsigned FRAME_W = DATA_W + ADDR_W;
  localparam int unsigned N_TGT   = LD_N_TGT;

  logic                         rst_q_n;
  logic [2:0]                   pins_s;
  logic                         s_en_n, s_clk, s_dat;
  logic [FRAME_W-1:0]           frame;
  logic [N_TGT-1:0]             wr_stb;
  logic [DATA_W-1:0]            wr_data;
  logic [N_TGT-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0]            ctrl_w, ref_w;

  cfg_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  cfg_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_q_n),
    .d({ser_en_n, ser_clk, ser_dat}), .q(pins_s));

  assign {s_en_n, s_clk, s_dat} = pins_s;

  cfg_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_q_n), .sclk(s_clk), .sdat(s_dat),
    .sen_n(s_en_n), .frame(frame));

  cfg_commit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_TGT(N_TGT)) u_commit (
    .clk(clk), .rst_n(rst_q_n), .sen_n(s_en_n), .frame(frame),
    .div_busy(div_busy), .wr_stb(wr_stb), .wr_data(wr_data));

  cfg_regbank #(.DATA_W(DATA_W), .N_TGT(N_TGT)) u_bank (
    .clk(clk), .rst_n(rst_q_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .words(words));

  assign ctrl_w    = words[T_CTRL];
  assign ref_w     = words[T_REF];
  assign main_a    = words[T_MAIN_A];
  assign main_b    = words[T_MAIN_B];
  assign test_word = words[T_TEST];

  assign run_a      = ctrl_w[C_RUN_A];
  assign run_b      = ctrl_w[C_RUN_B];
  assign port_out   = ctrl_w[C_PORT_LO +: C_PORT_W];
  assign dbl_en     = ctrl_w[C_DBL];
  assign lock_sel   = ctrl_w[C_LSEL_LO +: C_LSEL_W];
  assign cp_hi_a    = ctrl_w[C_CPHI_A];
  assign cp_hi_b    = ctrl_w[C_CPHI_B];
  assign ref_ratio  = ref_w[REF_W-1:0];
  assign ref_half_b = ref_w[REF_W];

  logic unused_payload;
  assign unused_payload = ^{ctrl_w[DATA_W-1:C_USED_W], ref_w[DATA_W-1:REF_W+1]};

  // R10: busy freezes every output for the following cycle
  a_r10_busy_freezes_outputs: assert property (@(posedge clk) disable iff (!rst_q_n)
    div_busy |=> $stable(words));

  // R1: loops stay powered down while the internal reset is held
  a_r1_reset_powered_down: assert property (@(posedge clk)
    !rst_q_n |-> (!run_a && !run_b));
endmodule

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;
  logic clk = 1'b0;
  logic rst_n, ser_clk, ser_dat, ser_en_n, div_busy;
  logic run_a, run_b, dbl_en, cp_hi_a, cp_hi_b, ref_half_b;
  logic [3:0]  port_out;
  logic [1:0]  lock_sel;
  logic [11:0] ref_ratio;
  logic [16:0] main_a, main_b, test_word;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [16:0] e_ma, e_mb, e_test;
  logic [10:0] e_ctrl;
  logic [12:0] e_ref;

  always #10 clk = ~clk;

  cfg_serial_loader u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_en_n(ser_en_n), .div_busy(div_busy), .run_a(run_a), .run_b(run_b),
    .port_out(port_out), .dbl_en(dbl_en), .lock_sel(lock_sel),
    .cp_hi_a(cp_hi_a), .cp_hi_b(cp_hi_b), .ref_ratio(ref_ratio),
    .ref_half_b(ref_half_b), .main_a(main_a), .main_b(main_b),
    .test_word(test_word));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " ctrl"}, 32'({cp_hi_b, cp_hi_a, lock_sel, dbl_en, port_out, run_b, run_a}), 32'(e_ctrl));
    chk({tag, " ref"},  32'({ref_half_b, ref_ratio}), 32'(e_ref));
    chk({tag, " main_a"}, 32'(main_a), 32'(e_ma));
    chk({tag, " main_b"}, 32'(main_b), 32'(e_mb));
    chk({tag, " test"}, 32'(test_word), 32'(e_test));
  endtask

  // shift n bits of v MSB first, then raise enable and wait 5 cycles (R11)
  task automatic xfer(input int n, input logic [63:0] v, input bit end_high);
    @(negedge clk) ser_en_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      if (!(end_high && i == 0)) ser_clk = 1'b0;
    end
    ser_en_n = 1'b1;
    repeat (5) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic model(input logic [3:0] a, input logic [16:0] d);
    case (a)
      4'b0000: e_mb   = d;
      4'b0001: e_ctrl = d[10:0];
      4'b0100: e_ma   = d;
      4'b0101: e_ref  = d[12:0];
      4'b0110: e_test = d;
      default: ;
    endcase
  endtask

  task automatic frame(input logic [3:0] a, input logic [16:0] d, input bit end_high);
    xfer(21, 64'({d, a}), end_high);
    if (!div_busy) model(a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [16:0] lim [4];
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_en_n = 1'b1; div_busy = 1'b0;
    e_ma = '0; e_mb = '0; e_test = '0; e_ctrl = '0; e_ref = '0;
    repeat (5) @(negedge clk);
    chk_all("R1 reset");
    chk("R1 loops down", 32'({run_a, run_b}), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_all("R1 after release");

    // R8 limits and patterns; R11 latency covered by every post-xfer check
    lim[0] = 17'd512; lim[1] = 17'd131071; lim[2] = 17'h15555; lim[3] = 17'h0AAAA;
    for (int i = 0; i < 4; i++) begin
      frame(4'b0100, lim[i], 1'b0);
      chk_all("R8 R11 loop A limit");
      frame(4'b0000, lim[3 - i], 1'b0);
      chk_all("R8 loop B limit");
    end
    for (int i = 0; i < 17; i++) begin
      frame(4'b0100, 17'(1) << i, 1'b0);
      frame(4'b0000, ~(17'(1) << i), 1'b0);
      chk_all("R4 R8 walking bit");
    end

    // R6 control fields; R5 odd steps leave serial clock high at commit
    for (int i = 0; i < 17; i++) begin
      frame(4'b0001, 17'(1) << i, i[0]);
      chk_all(i[0] ? "R5 R6 control, clk high" : "R6 control");
    end
    frame(4'b0001, 17'h007FF, 1'b0);
    chk_all("R6 control all");

    // R7 reference fields
    frame(4'b0101, {4'hF, 1'b0, 12'd8}, 1'b0);    chk_all("R7 ref min");
    frame(4'b0101, {4'h0, 1'b1, 12'd4095}, 1'b1); chk_all("R7 ref max half");
    frame(4'b0101, {4'hA, 1'b1, 12'h5A5}, 1'b0);  chk_all("R7 ref pattern");

    frame(4'b0110, 17'h1B3C7, 1'b0);
    chk_all("R4 test word");

    // R9 every unused address leaves outputs alone
    for (int a = 0; a < 16; a++) begin
      if (!(a inside {0, 1, 4, 5, 6})) begin
        frame(4'(a), 17'h1FFFF, 1'b0);
        chk_all("R9 unused code");
      end
    end

    // R3 extra leading bits dropped
    xfer(25, 64'({4'b1111, 17'h0ABCD, 4'b0100}), 1'b0);
    e_ma = 17'h0ABCD;
    chk_all("R3 long burst");

    // R2 clocks while idle ignored; R3 old bits retained across bursts
    ser_dat = 1'b1;
    for (int i = 0; i < 5; i++) begin
      repeat (4) @(negedge clk) ser_clk = 1'b1;
      repeat (4) @(negedge clk) ser_clk = 1'b0;
    end
    xfer(4, 64'h0, 1'b0);
    e_mb = {13'(17'h0ABCD), 4'b0100};
    chk_all("R2 R3 short burst reuses held bits");

    // R10 deferred commit
    @(negedge clk) div_busy = 1'b1;
    frame(4'b0100, 17'h00777, 1'b0);
    chk_all("R10 busy holds");
    repeat (20) @(negedge clk);
    chk_all("R10 still held");
    div_busy = 1'b0;
    repeat (2) @(negedge clk);
    e_ma = 17'h00777;
    chk_all("R10 applied after busy");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule